// File: doc/BRIEF.md
# Capability Memory Access Gate

This block is a purely combinational gate placed in front of a data memory port. On each access it receives the authorising capability, already decoded. That capability consists of a validity tag, a sealed flag, permission bits, and a base and top that are one bit wider than an address. Alongside it come the effective address, an access size, a load/store select and a flag marking a capability-width access. From these inputs the gate decides in the same cycle whether the access may go ahead or must trap, and it reports why. For stores, it also produces the tag value that must be written into the 65-bit memory slot next to the 64 data bits.

The memory pipeline uses `allow` to enable the request. It uses `trap` and `cause` to raise an exception. On a store it writes `wr_tag` in the same write as the data. A capability store therefore carries its tag in that write, and a narrow data store always clears the slot's tag. Bounds decoding and the memory array sit outside this block.

Top module: `cap_access_check`

## Requirements
- R1: When `auth_tag` is 0, the access traps with cause 1.
- R2: A tagged authorising capability that has `auth_sealed` set traps with cause 2, whatever the permissions are.
- R3: A load traps with cause 3 unless `auth_perm[0]` (read) is set. A store traps with cause 3 unless `auth_perm[1]` (write) is set.
- R4: A capability-width access (`is_cap`=1, load or store) also traps with cause 3 unless `auth_perm[2]` (capability transfer) is set.
- R5: A capability store whose source is tagged (`src_tag`=1) but not global (`src_global`=0) traps with cause 4 unless `auth_perm[3]` (local store) is set.
- R6: A capability-width access is 8 bytes wide regardless of `size_log2`. It traps with cause 5 when the low three address bits are not zero.
- R7: A data access covers 2^`size_log2` bytes. Every byte from `eff_addr` up to `eff_addr`+width-1 must satisfy base <= byte < top. Otherwise the access traps with cause 6. The comparison is one bit wider than an address, so a top of 2^ADDR_W admits the last byte.
- R8: When several faults apply together, only the first one in this order is reported: tag, seal, permission (R3 and R4), local store, alignment, bounds.
- R9: A data store (`is_store`=1, `is_cap`=0) always drives `wr_tag` to 0.
- R10: An allowed capability store drives `wr_tag` equal to `src_tag`. A load, or any trapped access, drives `wr_tag` to 0.
- R11: `allow` is always the inverse of `trap`, and `cause` is 0 exactly when `allow` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| auth_tag | input | 1 | Validity tag of the authorising capability |
| auth_sealed | input | 1 | Authorising capability has a nonzero object type |
| auth_perm | input | 4 | Permissions: bit0 read, bit1 write, bit2 capability transfer, bit3 local store |
| auth_base | input | ADDR_W+1 | Decoded lower bound, inclusive |
| auth_top | input | ADDR_W+1 | Decoded upper bound, exclusive |
| eff_addr | input | ADDR_W | Effective byte address of the access |
| size_log2 | input | 2 | Data access width as log2 of the byte count |
| is_store | input | 1 | 1 for a store, 0 for a load |
| is_cap | input | 1 | Access moves a whole capability with its tag |
| src_tag | input | 1 | Tag of the capability being stored |
| src_global | input | 1 | Global permission of the capability being stored |
| allow | output | 1 | Access may proceed |
| trap | output | 1 | Access must raise an exception |
| cause | output | 3 | Trap cause code (0 none, 1..6 as in R1..R7) |
| wr_tag | output | 1 | Tag to write with the store data |

## Verification
The bench builds the gate with ADDR_W=8, so base and top are 9 bits wide and the whole address space is 256 bytes. At that width, every address can be swept with every size, direction and width flag against several bound windows. The windows include one whose top is exactly 2^8 and an inverted one where base exceeds top. A second sweep crosses all 16 permission patterns with tag, seal, source tag and global flags at addresses chosen to also be misaligned or out of bounds. This exercises the priority order for every combination of faults.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

    localparam int PERM_W        = 4;
    localparam int PB_LOAD       = 0;
    localparam int PB_STORE      = 1;
    localparam int PB_CAPXFER    = 2;
    localparam int PB_LOCALST    = 3;
    localparam int SIZE_W        = 2;
    localparam int CAP_SIZE_LOG2 = 3;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_TAG    = 3'd1,
        CAUSE_SEAL   = 3'd2,
        CAUSE_PERM   = 3'd3,
        CAUSE_LOCAL  = 3'd4,
        CAUSE_ALIGN  = 3'd5,
        CAUSE_BOUNDS = 3'd6
    } cause_e;

    typedef struct packed {
        logic tag_fail;
        logic seal_fail;
        logic perm_fail;
        logic local_fail;
        logic align_fail;
        logic bounds_fail;
    } viol_t;

    // Width of the access in log2 bytes: capability moves are always full width.
    function automatic logic [SIZE_W-1:0] access_lg(input logic is_cap,
                                                    input logic [SIZE_W-1:0] sz);
        return is_cap ? SIZE_W'(CAP_SIZE_LOG2) : sz;
    endfunction

endpackage

// File: rtl/cap_chk_auth.sv
module cap_chk_auth
    import cap_chk_pkg::*;
(
    input  logic              tag,
    input  logic              sealed,
    input  logic [PERM_W-1:0] perm,
    input  logic              is_store,
    input  logic              is_cap,
    input  logic              src_tag,
    input  logic              src_global,
    output logic              tag_fail,
    output logic              seal_fail,
    output logic              perm_fail,
    output logic              local_fail
);
    logic dir_ok;
    logic xfer_ok;

    always_comb begin
        tag_fail   = ~tag;
        seal_fail  = sealed;
        dir_ok     = is_store ? perm[PB_STORE] : perm[PB_LOAD];
        xfer_ok    = ~is_cap | perm[PB_CAPXFER];
        perm_fail  = ~(dir_ok & xfer_ok);
        // A tagged non-global capability may only land through a local-store authority.
        local_fail = is_store & is_cap & src_tag & ~src_global & ~perm[PB_LOCALST];
    end
endmodule

// File: rtl/cap_chk_range.sv
module cap_chk_range
    import cap_chk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter bit ALIGN_CHECK = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   base,
    input  logic [ADDR_W:0]   top,
    input  logic [SIZE_W-1:0] size_log2,
    input  logic              is_cap,
    output logic              align_fail,
    output logic              bounds_fail
);
    localparam int EXT_W = ADDR_W + 1;

    logic [SIZE_W-1:0] lg;
    logic [EXT_W-1:0]  nbytes;
    logic [EXT_W-1:0]  start_x;
    logic [EXT_W-1:0]  end_x;

    always_comb begin
        lg          = access_lg(is_cap, size_log2);
        nbytes      = EXT_W'(1) << lg;
        start_x     = {1'b0, addr};
        end_x       = start_x + nbytes;     // exclusive end, never wraps in EXT_W bits
        bounds_fail = (start_x < base) | (end_x > top);
    end

    generate
        if (ALIGN_CHECK) begin : g_align
            assign align_fail = is_cap & (addr[CAP_SIZE_LOG2-1:0] != '0);
        end else begin : g_noalign
            assign align_fail = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cap_chk_resolve.sv
module cap_chk_resolve
    import cap_chk_pkg::*;
(
    input  viol_t  viol,
    input  logic   is_store,
    input  logic   is_cap,
    input  logic   src_tag,
    output logic   allow,
    output logic   trap,
    output cause_e cause,
    output logic   wr_tag
);
    always_comb begin
        if (viol.tag_fail)         cause = CAUSE_TAG;
        else if (viol.seal_fail)   cause = CAUSE_SEAL;
        else if (viol.perm_fail)   cause = CAUSE_PERM;
        else if (viol.local_fail)  cause = CAUSE_LOCAL;
        else if (viol.align_fail)  cause = CAUSE_ALIGN;
        else if (viol.bounds_fail) cause = CAUSE_BOUNDS;
        else                       cause = CAUSE_NONE;

        trap   = (cause != CAUSE_NONE);
        allow  = ~trap;
        // Tag leaves with the data only for a permitted capability-width store.
        wr_tag = allow & is_store & is_cap & src_tag;
    end
endmodule

// File: rtl/cap_access_check.sv
module cap_access_check
    import cap_chk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter bit ALIGN_CHECK = 1'b1
) (
    input  logic              auth_tag,
    input  logic              auth_sealed,
    input  logic [PERM_W-1:0] auth_perm,
    input  logic [ADDR_W:0]   auth_base,
    input  logic [ADDR_W:0]   auth_top,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [SIZE_W-1:0] size_log2,
    input  logic              is_store,
    input  logic              is_cap,
    input  logic              src_tag,
    input  logic              src_global,
    output logic              allow,
    output logic              trap,
    output logic [2:0]        cause,
    output logic              wr_tag
);
    viol_t  viol;
    cause_e cause_w;

    cap_chk_auth u_auth (
        .tag        (auth_tag),
        .sealed     (auth_sealed),
        .perm       (auth_perm),
        .is_store   (is_store),
        .is_cap     (is_cap),
        .src_tag    (src_tag),
        .src_global (src_global),
        .tag_fail   (viol.tag_fail),
        .seal_fail  (viol.seal_fail),
        .perm_fail  (viol.perm_fail),
        .local_fail (viol.local_fail)
    );

    cap_chk_range #(
        .ADDR_W      (ADDR_W),
        .ALIGN_CHECK (ALIGN_CHECK)
    ) u_range (
        .addr        (eff_addr),
        .base        (auth_base),
        .top         (auth_top),
        .size_log2   (size_log2),
        .is_cap      (is_cap),
        .align_fail  (viol.align_fail),
        .bounds_fail (viol.bounds_fail)
    );

    cap_chk_resolve u_resolve (
        .viol     (viol),
        .is_store (is_store),
        .is_cap   (is_cap),
        .src_tag  (src_tag),
        .allow    (allow),
        .trap     (trap),
        .cause    (cause_w),
        .wr_tag   (wr_tag)
    );

    assign cause = cause_w;
endmodule

// File: rtl/cap_access_check_sva.sv
module cap_access_check_sva
    import cap_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              auth_tag,
    input logic              auth_sealed,
    input logic [PERM_W-1:0] auth_perm,
    input logic [ADDR_W:0]   auth_base,
    input logic [ADDR_W:0]   auth_top,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [SIZE_W-1:0] size_log2,
    input logic              is_store,
    input logic              is_cap,
    input logic              src_tag,
    input logic              src_global,
    input logic              allow,
    input logic              trap,
    input logic [2:0]        cause,
    input logic              wr_tag
);
    logic [ADDR_W:0] span_end;

    always_comb begin
        span_end = {1'b0, eff_addr} + ((ADDR_W+1)'(1) << (is_cap ? 3 : size_log2));

        assert_untagged_R1: assert (auth_tag || (trap && cause == 3'd1))
            else $error("untagged authority not reported");
        assert_sealed_R2: assert (!(auth_tag && auth_sealed) || cause == 3'd2)
            else $error("sealed authority not reported");
        assert_dirperm_R3: assert (!(auth_tag && !auth_sealed &&
                                     !(is_store ? auth_perm[1] : auth_perm[0])) || cause == 3'd3)
            else $error("missing read/write permission not reported");
        assert_capxfer_R4: assert (!(auth_tag && !auth_sealed && is_cap && !auth_perm[2])
                                   || cause == 3'd3)
            else $error("missing capability transfer permission not reported");
        assert_inside_R7: assert (!allow || ({1'b0, eff_addr} >= auth_base && span_end <= auth_top))
            else $error("access allowed outside bounds");
        assert_aligned_R6: assert (!(allow && is_cap) || eff_addr[2:0] == 3'd0)
            else $error("misaligned capability access allowed");
        assert_datatag_R9: assert (!(is_store && !is_cap) || !wr_tag)
            else $error("data store kept a tag");
        assert_captag_R10: assert (!(allow && is_store && is_cap) || wr_tag == src_tag)
            else $error("capability store lost its tag");
        assert_notagtrap_R10: assert (allow || !wr_tag)
            else $error("trapped access wrote a tag");
        assert_excl_R11: assert (allow != trap && ((cause == 3'd0) == allow))
            else $error("allow/trap/cause disagree");
    end
endmodule

bind cap_access_check cap_access_check_sva #(.ADDR_W(ADDR_W)) u_sva (
    .auth_tag    (auth_tag),
    .auth_sealed (auth_sealed),
    .auth_perm   (auth_perm),
    .auth_base   (auth_base),
    .auth_top    (auth_top),
    .eff_addr    (eff_addr),
    .size_log2   (size_log2),
    .is_store    (is_store),
    .is_cap      (is_cap),
    .src_tag     (src_tag),
    .src_global  (src_global),
    .allow       (allow),
    .trap        (trap),
    .cause       (cause),
    .wr_tag      (wr_tag)
);

// File: tb/cap_access_check_tb.sv
module cap_access_check_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          auth_tag, auth_sealed;
    logic [3:0]    auth_perm;
    logic [AW:0]   auth_base, auth_top;
    logic [AW-1:0] eff_addr;
    logic [1:0]    size_log2;
    logic          is_store, is_cap, src_tag, src_global;
    logic          allow, trap, wr_tag;
    logic [2:0]    cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cap_access_check #(.ADDR_W(AW)) dut_i (
        .auth_tag(auth_tag), .auth_sealed(auth_sealed), .auth_perm(auth_perm),
        .auth_base(auth_base), .auth_top(auth_top), .eff_addr(eff_addr),
        .size_log2(size_log2), .is_store(is_store), .is_cap(is_cap),
        .src_tag(src_tag), .src_global(src_global),
        .allow(allow), .trap(trap), .cause(cause), .wr_tag(wr_tag)
    );

    // Independent model of R1..R11.
    function automatic int exp_cause();
        int w = is_cap ? 8 : (1 << size_log2);
        int s = int'(eff_addr);
        bit dir_ok = is_store ? auth_perm[1] : auth_perm[0];
        if (!auth_tag) return 1;
        if (auth_sealed) return 2;
        if (!dir_ok || (is_cap && !auth_perm[2])) return 3;
        if (is_store && is_cap && src_tag && !src_global && !auth_perm[3]) return 4;
        if (is_cap && (s % 8) != 0) return 5;
        if (s < int'(auth_base) || s + w > int'(auth_top)) return 6;
        return 0;
    endfunction

    function automatic string cause_req(int c);
        bit dir_ok = is_store ? auth_perm[1] : auth_perm[0];
        case (c)
            1: return "R1/R8";
            2: return "R2/R8";
            3: return dir_ok ? "R4/R8" : "R3/R8";
            4: return "R5/R8";
            5: return "R6/R8";
            6: return "R7/R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check_vec();
        int  ec;
        bit  ea, et;
        #2;
        ec = exp_cause();
        ea = (ec == 0);
        et = ea && is_store && is_cap && src_tag;
        checks++;
        if (int'(cause) != ec) begin
            errors++;
            $display("FAIL %s cause act=%0d exp=%0d addr=%0h sz=%0d cap=%0d st=%0d",
                     cause_req(ec), cause, ec, eff_addr, size_log2, is_cap, is_store);
        end
        checks++;
        if (allow != ea || trap != !ea) begin
            errors++;
            $display("FAIL R11 allow/trap act=%0b/%0b exp=%0b/%0b", allow, trap, ea, !ea);
        end
        checks++;
        if (wr_tag != et) begin
            errors++;
            $display("FAIL %s wr_tag act=%0b exp=%0b", (is_store && !is_cap) ? "R9" : "R10",
                     wr_tag, et);
        end
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Idle state: all inputs low, untagged authority must trap (R1).
        auth_tag = 0; auth_sealed = 0; auth_perm = 0; auth_base = 0; auth_top = 0;
        eff_addr = 0; size_log2 = 0; is_store = 0; is_cap = 0; src_tag = 0; src_global = 0;
        check_vec();

        // Sweep every address/size/direction/width against four windows (R6, R7, R9, R10, R11).
        auth_tag = 1; auth_perm = 4'hF; src_tag = 1; src_global = 1;
        for (int b = 0; b < 4; b++) begin
            case (b)
                0: begin auth_base = 9'h020; auth_top = 9'h060; end
                1: begin auth_base = 9'h000; auth_top = 9'h100; end   // top = 2^AW
                2: begin auth_base = 9'h081; auth_top = 9'h083; end
                default: begin auth_base = 9'h050; auth_top = 9'h040; end
            endcase
            for (int a = 0; a < 256; a++)
                for (int sz = 0; sz < 4; sz++)
                    for (int cp = 0; cp < 2; cp++)
                        for (int st = 0; st < 2; st++) begin
                            eff_addr = a[7:0]; size_log2 = sz[1:0];
                            is_cap = cp[0]; is_store = st[0];
                            check_vec();
                        end
        end

        // Permission / seal / tag / source cross with fault stacking (R1..R8).
        auth_base = 9'h000; auth_top = 9'h0F0; size_log2 = 2'd1;
        for (int t = 0; t < 2; t++)
            for (int se = 0; se < 2; se++)
                for (int p = 0; p < 16; p++)
                    for (int st = 0; st < 2; st++)
                        for (int cp = 0; cp < 2; cp++)
                            for (int sg = 0; sg < 4; sg++)
                                for (int ai = 0; ai < 4; ai++) begin
                                    auth_tag = t[0]; auth_sealed = se[0]; auth_perm = p[3:0];
                                    is_store = st[0]; is_cap = cp[0];
                                    src_tag = sg[0]; src_global = sg[1];
                                    case (ai)
                                        0: eff_addr = 8'h10;
                                        1: eff_addr = 8'h13;
                                        2: eff_addr = 8'hF8;
                                        default: eff_addr = 8'hEE;
                                    endcase
                                    check_vec();
                                end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule